// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer with Row-Change Wait

This block controls the read side of a synchronous burst memory. When a burst is launched, it captures a start address, a burst length (4 words, 8 words or continuous), a wrap enable, an order select and a latency count. After the latency has elapsed, it emits one word address per clock, with a valid strobe and a data word. The data word is modelled as a fixed function of the address, so no memory array is needed.

The array is organised in rows of 16 words. A burst whose start address is not a multiple of 4 must pause when its addresses move into a new row. During that pause the block raises a WAIT output, which tells the host to hold off. The pause length depends on two things: the position of the start address inside its group of four words, and the latency count. At most one pause happens per burst.

The WAIT pin is driven only while the chip is enabled and no register location is being read. The block exposes the drive enable as a separate output, so the pad can tri-state WAIT when it is not driven.

Top module: `burst_wait_seq`

## Requirements
- R1: A burst is accepted on a clock edge where `start` and `ce` are both high and the sequencer is idle. With latency count `lat` (at least 1), the first `beat_valid` appears in the cycle that follows the lat-th edge after the accepting edge. Before that, `beat_valid` and `wait_o` stay low.
- R2: `blen_sel` selects the burst length: code 0 gives 4 words, code 1 gives 8 words, codes 2 and 3 give continuous. With wrap off and order linear (`ilv_en`=0), a 4-word or 8-word burst presents the start address plus 0, 1, 2 and so on. The burst ends after exactly 4 or 8 beats, and `beat_valid` is low on the following cycle.
- R3: In 4-word or 8-word mode with `wrap_en`=1 and linear order, beat k has address (start with its low log2(N) bits cleared) OR ((start + k) mod N), where N is the burst length.
- R4: In 4-word or 8-word mode with `ilv_en`=1, beat k has address (start with its low log2(N) bits cleared) OR ((start XOR k) mod N). This holds whatever the value of `wrap_en`.
- R5: In continuous mode, beat k has address start + k, whatever the values of `wrap_en` and `ilv_en`. The burst runs until `ce` falls.
- R6: If start address bits [1:0] are 00, WAIT is never asserted during the burst, even when the burst moves into a new 16-word row.
- R7: For a start offset o = start[1:0] in the range 1 to 3, the pause lasts max(0, lat + o - 4) cycles. The pause begins in place of the first beat whose address bits [AW-1:4] differ from those of the previous beat.
- R8: In continuous mode only the first row change pauses. Later row changes in the same burst present their beats without WAIT.
- R9: A 4-word or 8-word burst with `wrap_en`=1 never asserts WAIT.
- R10: While `wait_o` is high, `beat_valid` is low. After the pause, the beat whose address opened the new row is presented, and the sequence continues without skipping an address.
- R11: `wait_oe` equals `ce` AND NOT `reg_read`. `wait_o` is low whenever `wait_oe` is low.
- R12: Dropping `ce` ends any burst at the next edge. From then on `beat_valid` is low until a new burst is started.
- R13: `beat_data` equals `beat_addr` XOR the parameter SEED (default 16'hA5C3) while `beat_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Chip enable, active high |
| reg_read | input | 1 | High while a register location is read; releases WAIT |
| start | input | 1 | Launch a burst with the inputs below |
| start_addr | input | AW | First word address of the burst |
| blen_sel | input | 2 | Burst length: 0 = 4 words, 1 = 8 words, 2/3 = continuous |
| wrap_en | input | 1 | Wrap inside the 4- or 8-word group |
| ilv_en | input | 1 | Interleaved (XOR) order for 4- and 8-word bursts |
| lat | input | LW | Latency count in clocks |
| beat_valid | output | 1 | A data beat is presented this cycle |
| beat_addr | output | AW | Word address of the current beat |
| beat_data | output | DW | Modelled array data of the current beat |
| wait_o | output | 1 | WAIT level, high during a row-change pause |
| wait_oe | output | 1 | WAIT pad drive enable; low means high impedance |

## Verification
The bench uses start offsets 0, 1, 2 and 3, placed so that a 4-word, 8-word or continuous burst either crosses a 16-word row or stays inside one. This separates the pause-length formula for each offset from the aligned case, which never pauses. A latency small enough to clamp the pause to zero is also tried, which shows the clamp apart from a missing pause. Wrapped and interleaved 8-word bursts started near the end of a row show that the order stays inside its group and that wrapping suppresses WAIT. A long continuous burst crosses three rows, which tells the single pause apart from a pause at every row. Register reads and chip-enable drops during a burst confirm the release of WAIT and the abort.

// File: rtl/bws_pkg.sv
package bws_pkg;

    typedef enum logic [1:0] {
        BL_4    = 2'd0,
        BL_8    = 2'd1,
        BL_CONT = 2'd2
    } blen_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LAT   = 2'd1,
        S_DATA  = 2'd2,
        S_STALL = 2'd3
    } st_e;

    typedef struct packed {
        blen_e blen;
        logic  wrap;
        logic  ilv;
    } cfg_t;

    localparam int ROW_BITS = 4;

    function automatic blen_e decode_blen(input logic [1:0] sel);
        case (sel)
            2'd0:    return BL_4;
            2'd1:    return BL_8;
            default: return BL_CONT;
        endcase
    endfunction

    // mask of the in-group index bits; zero for continuous bursts
    function automatic logic [2:0] grp_mask(input blen_e b);
        case (b)
            BL_4:    return 3'd3;
            BL_8:    return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/bws_addr_gen.sv
module bws_addr_gen
    import bws_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] idx,
    input  cfg_t          cfg,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] mask;
    logic [AW-1:0] lin;

    always_comb begin
        mask = AW'(grp_mask(cfg.blen));
        lin  = base + idx;
        if (cfg.blen == BL_CONT)
            addr = lin;
        else if (cfg.ilv)
            addr = (base & ~mask) | ((base ^ idx) & mask);
        else if (cfg.wrap)
            addr = (base & ~mask) | (lin & mask);
        else
            addr = lin;
    end
endmodule

// File: rtl/bws_stall_calc.sv
module bws_stall_calc
    import bws_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic [1:0]    off,
    input  logic [LW-1:0] lat,
    input  cfg_t          cfg,
    output logic [LW-1:0] len
);
    logic [LW:0] sum;
    logic        allowed;

    always_comb begin
        sum     = {1'b0, lat} + (LW+1)'(off);
        allowed = (off != 2'd0) && !((cfg.blen != BL_CONT) && cfg.wrap);
        len     = (allowed && sum > (LW+1)'(4)) ? LW'(sum - (LW+1)'(4)) : '0;
    end
endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq
    import bws_pkg::*;
#(
    parameter int            AW   = 16,
    parameter int            DW   = 16,
    parameter int            LW   = 4,
    parameter logic [DW-1:0] SEED = 'hA5C3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          reg_read,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    blen_sel,
    input  logic          wrap_en,
    input  logic          ilv_en,
    input  logic [LW-1:0] lat,
    output logic          beat_valid,
    output logic [AW-1:0] beat_addr,
    output logic [DW-1:0] beat_data,
    output logic          wait_o,
    output logic          wait_oe
);
    localparam int LANES = 2;

    st_e           st_q;
    cfg_t          cfg_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] idx_q;
    logic [LW-1:0] lat_q;
    logic [LW-1:0] cnt_q;
    logic          stalled_q;
    logic [LW-1:0] stall_len;
    logic [AW-1:0] lane_addr [LANES];
    logic          last_beat;
    logic          row_change;

    // lane 0: current beat, lane 1: following beat
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bws_addr_gen #(.AW(AW)) u_ag (
            .base (base_q),
            .idx  (idx_q + AW'(g)),
            .cfg  (cfg_q),
            .addr (lane_addr[g])
        );
    end

    bws_stall_calc #(.LW(LW)) u_sc (
        .off (base_q[1:0]),
        .lat (lat_q),
        .cfg (cfg_q),
        .len (stall_len)
    );

    always_comb begin
        last_beat  = (cfg_q.blen == BL_4 && idx_q == AW'(3)) ||
                     (cfg_q.blen == BL_8 && idx_q == AW'(7));
        row_change = lane_addr[1][AW-1:ROW_BITS] != lane_addr[0][AW-1:ROW_BITS];
    end

    always_ff @(posedge clk) begin
        if (rst || !ce) begin
            st_q      <= S_IDLE;
            idx_q     <= '0;
            cnt_q     <= '0;
            stalled_q <= 1'b0;
            if (rst) begin
                cfg_q  <= '{blen: BL_4, wrap: 1'b0, ilv: 1'b0};
                base_q <= '0;
                lat_q  <= '0;
            end
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    st_q      <= S_LAT;
                    base_q    <= start_addr;
                    cfg_q     <= '{blen: decode_blen(blen_sel), wrap: wrap_en, ilv: ilv_en};
                    lat_q     <= lat;
                    cnt_q     <= LW'(1);
                    idx_q     <= '0;
                    stalled_q <= 1'b0;
                end
                S_LAT: begin
                    if (cnt_q >= lat_q) st_q <= S_DATA;
                    else                cnt_q <= cnt_q + LW'(1);
                end
                S_DATA: begin
                    if (last_beat) begin
                        st_q <= S_IDLE;
                    end else begin
                        idx_q <= idx_q + AW'(1);
                        if (!stalled_q && stall_len != '0 && row_change) begin
                            st_q      <= S_STALL;
                            cnt_q     <= stall_len;
                            stalled_q <= 1'b1;
                        end
                    end
                end
                S_STALL: begin
                    if (cnt_q == LW'(1)) st_q <= S_DATA;
                    else                 cnt_q <= cnt_q - LW'(1);
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        beat_valid = (st_q == S_DATA) && ce;
        beat_addr  = lane_addr[0];
        beat_data  = DW'(lane_addr[0]) ^ SEED;
        wait_oe    = ce && !reg_read;
        wait_o     = wait_oe && (st_q == S_STALL);
    end

    // ---------------- assertions ----------------
    logic [LW-1:0] run_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            run_q  <= (st_q == S_STALL) ? run_q + LW'(1) : '0;
            seen_q <= (st_q == S_IDLE) ? 1'b0 : (seen_q || st_q == S_STALL);
        end
    end

    p_stall_len_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == S_STALL && st_q == S_DATA) |-> run_q == stall_len);

    p_single_stall_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == S_STALL) |-> !seen_q);

    p_wrap_no_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_STALL) |-> !(cfg_q.blen != BL_CONT && cfg_q.wrap));

    p_aligned_no_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_STALL) |-> base_q[1:0] != 2'd0);

    p_release_r11: assert property (@(posedge clk) disable iff (rst)
        (!ce || reg_read) |-> (!wait_oe && !wait_o));

    p_linear_step_r2: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid) && $past(ce) &&
         (cfg_q.blen == BL_CONT || (!cfg_q.wrap && !cfg_q.ilv)))
        |-> beat_addr == $past(beat_addr) + AW'(1));

    p_wait_blocks_beat_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == S_STALL && ce) |-> beat_addr != $past(lane_addr[0]) - AW'(1));
endmodule

// File: tb/burst_wait_seq_bench.sv
module burst_wait_seq_bench;
    localparam logic [15:0] SEED = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b1;
    logic        reg_read = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic [1:0]  blen_sel = '0;
    logic        wrap_en = 1'b0;
    logic        ilv_en = 1'b0;
    logic [3:0]  lat = 4'd2;
    logic        beat_valid;
    logic [15:0] beat_addr;
    logic [15:0] beat_data;
    logic        wait_o;
    logic        wait_oe;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_wait_seq u_burst_wait_seq (
        .clk, .rst, .ce, .reg_read, .start, .start_addr, .blen_sel,
        .wrap_en, .ilv_en, .lat, .beat_valid, .beat_addr, .beat_data,
        .wait_o, .wait_oe
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] e_addr(input logic [15:0] a, input logic [1:0] bl,
                                           input bit w, input bit il, input int j);
        logic [15:0] m;
        m = (bl == 2'd0) ? 16'd3 : (bl == 2'd1) ? 16'd7 : 16'd0;
        if (m == 0)  return a + 16'(j);
        if (il)      return (a & ~m) | ((a ^ 16'(j)) & m);
        if (w)       return (a & ~m) | ((a + 16'(j)) & m);
        return a + 16'(j);
    endfunction

    task automatic run_burst(input logic [15:0] a, input logic [1:0] bl, input bit w,
                             input bit il, input logic [3:0] lt, input int ncont, input bit probe);
        int nb, len, off;
        bit grp, stalled;
        string ta, tw;
        grp = (bl < 2'd2);
        nb  = (bl == 2'd0) ? 4 : (bl == 2'd1) ? 8 : ncont;
        off = int'(a[1:0]);
        len = (off == 0 || (grp && w)) ? 0 : ((int'(lt) + off - 4) > 0 ? int'(lt) + off - 4 : 0);
        ta  = !grp ? "R5" : il ? "R4" : w ? "R3" : "R2";
        tw  = (grp && w) ? "R9" : off == 0 ? "R6" : "R7";
        stalled = 1'b0;
        @(negedge clk);
        start_addr = a; blen_sel = bl; wrap_en = w; ilv_en = il; lat = lt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!beat_valid && !wait_o, "R1", {beat_valid, wait_o}, 0);
        for (int k = 1; k < int'(lt); k++) begin
            @(negedge clk);
            chk(!beat_valid && !wait_o, "R1", {beat_valid, wait_o}, 0);
        end
        for (int j = 0; j < nb; j++) begin
            @(negedge clk);
            if (j > 0 && !stalled && len > 0 &&
                e_addr(a, bl, w, il, j) >> 4 != e_addr(a, bl, w, il, j - 1) >> 4) begin
                stalled = 1'b1;
                for (int s = 0; s < len; s++) begin
                    chk(wait_o === 1'b1, "R7", wait_o, 1);
                    chk(beat_valid === 1'b0, "R10", beat_valid, 0);
                    if (probe && s == 0) begin
                        reg_read = 1'b1;
                        #1;
                        chk(!wait_oe && !wait_o, "R11", {wait_oe, wait_o}, 0);
                        reg_read = 1'b0;
                        #1;
                    end
                    @(negedge clk);
                end
            end
            chk(beat_valid === 1'b1, ta, beat_valid, 1);
            chk(beat_addr === e_addr(a, bl, w, il, j), ta, beat_addr, e_addr(a, bl, w, il, j));
            chk(beat_data === (e_addr(a, bl, w, il, j) ^ SEED), "R13", beat_data,
                e_addr(a, bl, w, il, j) ^ SEED);
            chk(wait_o === 1'b0, stalled ? (grp ? "R10" : "R8") : tw, wait_o, 0);
        end
        if (grp) begin
            @(negedge clk);
            chk(beat_valid === 1'b0, "R2", beat_valid, 0);
        end else begin
            ce = 1'b0;
            #1;
            chk(wait_oe === 1'b0, "R11", wait_oe, 0);
            @(negedge clk);
            chk(beat_valid === 1'b0 && wait_o === 1'b0, "R12", {beat_valid, wait_o}, 0);
            @(negedge clk);
            chk(beat_valid === 1'b0, "R12", beat_valid, 0);
            ce = 1'b1;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(beat_valid === 1'b0 && wait_o === 1'b0, "R1", {beat_valid, wait_o}, 0);
        chk(wait_oe === 1'b1, "R11", wait_oe, 1);
    endtask

    task automatic t_pad_release();
        @(negedge clk);
        reg_read = 1'b1; #1;
        chk(wait_oe === 1'b0 && wait_o === 1'b0, "R11", {wait_oe, wait_o}, 0);
        reg_read = 1'b0; ce = 1'b0; #1;
        chk(wait_oe === 1'b0, "R11", wait_oe, 0);
        ce = 1'b1; #1;
        chk(wait_oe === 1'b1, "R11", wait_oe, 1);
    endtask

    task automatic t_linear_nowrap();
        run_burst(16'h001E, 2'd1, 1'b0, 1'b0, 4'd5, 0, 1'b0); // off 2 -> 3 wait
        run_burst(16'h003D, 2'd0, 1'b0, 1'b0, 4'd6, 0, 1'b0); // off 1 -> 3 wait
        run_burst(16'h00FF, 2'd0, 1'b0, 1'b0, 4'd4, 0, 1'b0); // off 3 -> 3 wait
        run_burst(16'h00FD, 2'd0, 1'b0, 1'b0, 4'd4, 0, 1'b0); // off 1 -> 1 wait
    endtask

    task automatic t_aligned_and_clamp();
        run_burst(16'h001C, 2'd1, 1'b0, 1'b0, 4'd6, 0, 1'b0); // R6 crosses, aligned
        run_burst(16'h002E, 2'd0, 1'b0, 1'b0, 4'd2, 0, 1'b0); // R7 clamp to 0
        run_burst(16'h0040, 2'd0, 1'b0, 1'b0, 4'd1, 0, 1'b0); // R1 minimal latency
    endtask

    task automatic t_wrap_and_interleave();
        run_burst(16'h001D, 2'd1, 1'b1, 1'b0, 4'd7, 0, 1'b0); // R3 and R9
        run_burst(16'h001D, 2'd1, 1'b1, 1'b1, 4'd7, 0, 1'b0); // R4
        run_burst(16'h002F, 2'd0, 1'b0, 1'b1, 4'd5, 0, 1'b0); // R4 without wrap
    endtask

    task automatic t_continuous();
        run_burst(16'h007D, 2'd2, 1'b1, 1'b1, 4'd7, 40, 1'b0); // R5, R8: 3 rows
        run_burst(16'h00F3, 2'd3, 1'b0, 1'b0, 4'd3, 20, 1'b1); // R11 during wait
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pad_release();
        t_linear_nowrap();
        t_aligned_and_clamp();
        t_wrap_and_interleave();
        t_continuous();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule